// File: doc/BRIEF.md
# Segmented Associative Data Cache Controller

This block is a data cache that sits between a CPU load/store port and a word-wide backing memory. Storage is split into four segments. The segment is chosen by two address bits. Inside a segment every line is a candidate for every tag, so a lookup compares the request tag against all lines of that segment at once. A read that finds its line answers without touching memory. A read that misses picks a victim line and refills it from memory, four words in ascending order. If the victim is dirty, its four words are written back first. Stores never allocate a line. A store that misses goes straight to memory. Under write-through, a store that hits updates the line and also writes the word to memory.

Victims come from a free-running counter that walks only the unlocked lines, which are the indices at or above `lock_lines`. An invalid unlocked line is always taken before the counter is consulted. When `lock_lines` covers every line, reads bypass the cache and fetch a single word. Setting `flush` for one cycle starts a sweep over every line: dirty lines are written back and every line is then invalidated.

The CPU port uses valid/ready. While `req_valid` is high and `req_ready` is low, the request stalls and must be held unchanged. A read returns data on `rsp_valid` one cycle after it is accepted, and the response has no back-pressure. The memory port is a request/acknowledge pair: `mem_valid` and its fields stay constant until `mem_ready` is high at a clock edge. Read data is taken from `mem_rdata` in that same cycle.

Top module: `seg_dcache`

## Requirements
- R1: An address splits into word-in-line bits [3:2], segment bits [5:4] and tag bits [31:6]. Any line of a segment may hold any tag, and at most one line of a segment matches a given tag.
- R2: A read hit is accepted in the cycle it is presented. It drives `rsp_valid` with the stored word in the next cycle and makes no memory transaction.
- R3: A read miss with at least one unlocked line fetches the whole line with four single-word memory reads, word offsets 0,1,2,3 in that order, and then completes as a hit. When `lock_lines` equals the line count, a read makes exactly one memory read of its own word and allocates nothing.
- R4: A write miss makes exactly one memory write, carrying the request's byte enables, and allocates no line. A later read of that address misses.
- R5: The victim is the lowest-index invalid line with index not below `lock_lines`. If there is none, the victim is the value of a counter that cycles over the unlocked indices. Lines below `lock_lines` are never replaced.
- R6: In write-back mode (`wb_mode`=1), a write hit merges the enabled bytes (enable bit i selects data bits 8i+7:8i) into the line, marks it dirty and makes no memory transaction. A dirty victim is written back as four words before the refill.
- R7: In write-through mode (`wb_mode`=0), a write hit updates the line and makes one memory write of the word. Lines are never marked dirty, so evictions make no memory writes.
- R8: A write-back write hit is accepted in the cycle it is presented. The exception is when a write was accepted in the previous cycle; the write hit then stalls for exactly one cycle.
- R9: After a one-cycle `flush` pulse, `req_ready` stays low while every dirty line is written back (four words each) and every line is invalidated. The next read of any address then misses.
- R10: A stalled CPU request is held stable by the requester. A memory request keeps `mem_valid`, `mem_addr`, `mem_we` and `mem_wdata` stable until acknowledged.
- R11: During and right after reset, all lines are invalid, `mem_valid` and `rsp_valid` are low, and `req_ready` is low while `req_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_mode | input | 1 | 1 = write-back, 0 = write-through |
| lock_lines | input | LOCK_W (7) | Number of lowest-index lines locked in each segment |
| flush | input | 1 | One-cycle pulse that starts clean-and-invalidate of all lines |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | CPU request accepted this cycle |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address |
| req_be | input | 4 | Store byte enables |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Load data valid |
| rsp_rdata | output | 32 | Load data |
| mem_valid | output | 1 | Memory word request |
| mem_ready | input | 1 | Memory acknowledge |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Memory write byte enables |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ready` |

## Verification
The bench runs a cache of four lines per segment. It sweeps loads over every segment with several tags, first cold and then warm. Memory-traffic counts separate misses from hits, and the logged fill offsets show the refill order. Stores run in both write policies, and against lines that are resident and lines that are not. The traffic each case produces shows whether dirty marking, write-through and no-allocate behave as required. The bench then raises the lock count to partial and to full coverage while streaming misses through one segment. Locked lines must keep hitting, and full lock must bypass the cache. A flush over a mixed set of dirty and clean lines must produce exactly the expected number of write-backs.

// File: rtl/dc_pkg.sv
package dc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVICT,
    ST_FILL,
    ST_UNC,
    ST_MWR,
    ST_FSCAN,
    ST_FWB
  } dc_state_e;
endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store #(
  parameter int SEGS  = 4,
  parameter int LINES = 64,
  parameter int TAG_W = 26,
  localparam int SEG_W = $clog2(SEGS),
  localparam int IDX_W = $clog2(LINES),
  localparam int LN_W  = SEG_W + IDX_W,
  localparam int NL    = SEGS * LINES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEG_W-1:0] lk_seg,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output logic [LINES-1:0] seg_valid,
  input  logic [LN_W-1:0]  rd_line,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             alloc_en,
  input  logic [LN_W-1:0]  alloc_line,
  input  logic [TAG_W-1:0] alloc_tag,
  input  logic             dirty_en,
  input  logic [LN_W-1:0]  dirty_line,
  input  logic             clr_en,
  input  logic [LN_W-1:0]  clr_line
);
  logic [TAG_W-1:0] tag_q [NL];
  logic [NL-1:0]    val_q;
  logic [NL-1:0]    dty_q;
  logic [LINES-1:0] hit_vec;

  for (genvar gi = 0; gi < LINES; gi++) begin : g_cmp
    logic [LN_W-1:0] li;
    assign li            = {lk_seg, IDX_W'(gi)};
    assign hit_vec[gi]   = val_q[li] && (tag_q[li] == lk_tag);
    assign seg_valid[gi] = val_q[li];
  end

  always_comb begin
    hit_idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end
  assign hit = |hit_vec;

  assign rd_valid = val_q[rd_line];
  assign rd_dirty = dty_q[rd_line];
  assign rd_tag   = tag_q[rd_line];

  always_ff @(posedge clk) begin
    if (alloc_en) tag_q[alloc_line] <= alloc_tag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q <= '0;
      dty_q <= '0;
    end else begin
      if (alloc_en) begin
        val_q[alloc_line] <= 1'b1;
        dty_q[alloc_line] <= 1'b0;
      end
      if (dirty_en) dty_q[dirty_line] <= 1'b1;
      if (clr_en) begin
        val_q[clr_line] <= 1'b0;
        dty_q[clr_line] <= 1'b0;
      end
    end
  end

  assert_single_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

// File: rtl/dc_victim_pick.sv
module dc_victim_pick #(
  parameter int LINES = 64,
  localparam int IDX_W  = $clog2(LINES),
  localparam int LOCK_W = $clog2(LINES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LOCK_W-1:0] lock,
  input  logic [LINES-1:0]  seg_valid,
  output logic [IDX_W-1:0]  vic_idx,
  output logic              all_locked
);
  logic [IDX_W-1:0]  rnd_q;
  logic [LOCK_W-1:0] rnd_ext;
  logic              free_found;
  logic [IDX_W-1:0]  free_idx;

  assign rnd_ext    = LOCK_W'(rnd_q);
  assign all_locked = (lock >= LOCK_W'(LINES));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rnd_q <= '0;
    end else if (rnd_ext < lock || rnd_ext + LOCK_W'(1) >= LOCK_W'(LINES)) begin
      rnd_q <= lock[IDX_W-1:0];
    end else begin
      rnd_q <= rnd_q + IDX_W'(1);
    end
  end

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (!seg_valid[i] && LOCK_W'(i) >= lock) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (free_found)          vic_idx = free_idx;
    else if (rnd_ext < lock) vic_idx = lock[IDX_W-1:0];
    else                     vic_idx = rnd_q;
  end

  assert_victim_unlocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !all_locked |-> LOCK_W'(vic_idx) >= lock);
endmodule

// File: rtl/dc_line_ram.sv
module dc_line_ram #(
  parameter int DEPTH = 1024,
  parameter int DW    = 32,
  localparam int AW_R = $clog2(DEPTH),
  localparam int BE_W = DW / 8
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW_R-1:0] waddr,
  input  logic [BE_W-1:0] wbe,
  input  logic [DW-1:0]   wdata,
  input  logic [AW_R-1:0] raddr,
  output logic [DW-1:0]   rdata
);
  logic [DW-1:0] mem_q [DEPTH];

  assign rdata = mem_q[raddr];

  for (genvar gb = 0; gb < BE_W; gb++) begin : g_lane
    always_ff @(posedge clk) begin
      if (we && wbe[gb]) mem_q[waddr][8*gb +: 8] <= wdata[8*gb +: 8];
    end
  end
endmodule

// File: rtl/seg_dcache.sv
module seg_dcache
  import dc_pkg::*;
#(
  parameter int SEGS  = 4,
  parameter int LINES = 64,
  parameter int WORDS = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int BE_W    = DW / 8,
  localparam int BO_W    = $clog2(BE_W),
  localparam int SEG_W   = $clog2(SEGS),
  localparam int IDX_W   = $clog2(LINES),
  localparam int OFF_W   = $clog2(WORDS),
  localparam int TAG_LSB = BO_W + OFF_W + SEG_W,
  localparam int TAG_W   = AW - TAG_LSB,
  localparam int LOCK_W  = $clog2(LINES + 1),
  localparam int LN_W    = SEG_W + IDX_W,
  localparam int WA_W    = LN_W + OFF_W,
  localparam int NL      = SEGS * LINES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wb_mode,
  input  logic [LOCK_W-1:0] lock_lines,
  input  logic              flush,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [AW-1:0]     req_addr,
  input  logic [BE_W-1:0]   req_be,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [BE_W-1:0]   mem_be,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata
);
  dc_state_e state_q;
  logic [OFF_W-1:0] wcnt_q;
  logic [IDX_W-1:0] vic_q;
  logic [LN_W-1:0]  fptr_q;
  logic             fpend_q, pass_q, wr_busy_q;
  logic [DW-1:0]    hold_q;

  logic [OFF_W-1:0] a_word;
  logic [SEG_W-1:0] a_seg;
  logic [TAG_W-1:0] a_tag;
  assign a_word = req_addr[BO_W +: OFF_W];
  assign a_seg  = req_addr[BO_W + OFF_W +: SEG_W];
  assign a_tag  = req_addr[AW-1 -: TAG_W];
  logic unused_addr_bits;
  assign unused_addr_bits = ^req_addr[BO_W-1:0];

  logic             hit, rd_valid, rd_dirty, all_locked;
  logic [IDX_W-1:0] hit_idx, vic_idx;
  logic [LINES-1:0] seg_valid;
  logic [TAG_W-1:0] rd_tag;
  logic [LN_W-1:0]  rd_line;
  logic             alloc_en, dirty_en, clr_en;
  logic [DW-1:0]    ram_rdata;
  logic [WA_W-1:0]  ram_raddr, ram_waddr;
  logic             ram_we;
  logic [BE_W-1:0]  ram_be;
  logic [DW-1:0]    ram_wdata;

  logic mem_hs, last_word, accept, flushing, fdone;
  assign mem_hs    = mem_valid && mem_ready;
  assign last_word = (wcnt_q == OFF_W'(WORDS - 1));
  assign accept    = req_valid && req_ready;
  assign flushing  = (state_q == ST_FSCAN) || (state_q == ST_FWB);
  assign fdone     = (fptr_q == LN_W'(NL - 1));

  // Ready: pass-through completions, read hits, write-back write hits.
  always_comb begin
    req_ready = 1'b0;
    if (state_q == ST_IDLE && !fpend_q && req_valid) begin
      if (pass_q)       req_ready = 1'b1;
      else if (!req_we) req_ready = hit;
      else              req_ready = hit && wb_mode && !wr_busy_q;
    end
  end

  assign rd_line = flushing ? fptr_q
                 : {a_seg, (state_q == ST_IDLE) ? vic_idx : vic_q};

  dc_tag_store #(.SEGS(SEGS), .LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_seg     (a_seg),
    .lk_tag     (a_tag),
    .hit        (hit),
    .hit_idx    (hit_idx),
    .seg_valid  (seg_valid),
    .rd_line    (rd_line),
    .rd_valid   (rd_valid),
    .rd_dirty   (rd_dirty),
    .rd_tag     (rd_tag),
    .alloc_en   (alloc_en),
    .alloc_line ({a_seg, vic_q}),
    .alloc_tag  (a_tag),
    .dirty_en   (dirty_en),
    .dirty_line ({a_seg, hit_idx}),
    .clr_en     (clr_en),
    .clr_line   (fptr_q)
  );

  dc_victim_pick #(.LINES(LINES)) u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .lock       (lock_lines),
    .seg_valid  (seg_valid),
    .vic_idx    (vic_idx),
    .all_locked (all_locked)
  );

  always_comb begin
    case (state_q)
      ST_EVICT: ram_raddr = {a_seg, vic_q, wcnt_q};
      ST_FWB:   ram_raddr = {fptr_q, wcnt_q};
      default:  ram_raddr = {a_seg, hit_idx, a_word};
    endcase
  end

  always_comb begin
    if (state_q == ST_FILL) begin
      ram_we    = mem_hs;
      ram_waddr = {a_seg, vic_q, wcnt_q};
      ram_be    = '1;
      ram_wdata = mem_rdata;
    end else begin
      ram_we    = accept && req_we && hit;
      ram_waddr = {a_seg, hit_idx, a_word};
      ram_be    = req_be;
      ram_wdata = req_wdata;
    end
  end

  dc_line_ram #(.DEPTH(NL * WORDS), .DW(DW)) u_data (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wbe   (ram_be),
    .wdata (ram_wdata),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );

  assign alloc_en = (state_q == ST_FILL) && mem_hs && last_word;
  assign dirty_en = accept && req_we && hit && wb_mode;
  assign clr_en   = ((state_q == ST_FSCAN) && !(rd_valid && rd_dirty))
                 || ((state_q == ST_FWB) && mem_hs && last_word);

  // Memory side request.
  always_comb begin
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_be    = '1;
    mem_wdata = ram_rdata;
    case (state_q)
      ST_EVICT: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {rd_tag, a_seg, wcnt_q, BO_W'(0)};
      end
      ST_FWB: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {rd_tag, fptr_q[LN_W-1 -: SEG_W], wcnt_q, BO_W'(0)};
      end
      ST_FILL: begin
        mem_valid = 1'b1;
        mem_addr  = {a_tag, a_seg, wcnt_q, BO_W'(0)};
      end
      ST_UNC: begin
        mem_valid = 1'b1;
        mem_addr  = {req_addr[AW-1:BO_W], BO_W'(0)};
      end
      ST_MWR: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {req_addr[AW-1:BO_W], BO_W'(0)};
        mem_be    = req_be;
        mem_wdata = req_wdata;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      wcnt_q    <= '0;
      vic_q     <= '0;
      fptr_q    <= '0;
      fpend_q   <= 1'b0;
      pass_q    <= 1'b0;
      wr_busy_q <= 1'b0;
      hold_q    <= '0;
    end else begin
      wr_busy_q <= accept && req_we;
      if (accept) pass_q <= 1'b0;
      if (flush) fpend_q <= 1'b1;
      if (mem_hs) wcnt_q <= wcnt_q + OFF_W'(1);
      case (state_q)
        ST_IDLE: begin
          wcnt_q <= '0;
          if (fpend_q) begin
            state_q <= ST_FSCAN;
            fptr_q  <= '0;
          end else if (req_valid && !pass_q) begin
            if (!req_we && !hit) begin
              if (all_locked) begin
                state_q <= ST_UNC;
              end else begin
                vic_q   <= vic_idx;
                state_q <= (rd_valid && rd_dirty) ? ST_EVICT : ST_FILL;
              end
            end else if (req_we && (!hit || !wb_mode)) begin
              state_q <= ST_MWR;
            end
          end
        end
        ST_EVICT: if (mem_hs && last_word) state_q <= ST_FILL;
        ST_FILL:  if (mem_hs && last_word) state_q <= ST_IDLE;
        ST_UNC: if (mem_hs) begin
          hold_q  <= mem_rdata;
          pass_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        ST_MWR: if (mem_hs) begin
          pass_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        ST_FSCAN: begin
          wcnt_q <= '0;
          if (rd_valid && rd_dirty) begin
            state_q <= ST_FWB;
          end else if (fdone) begin
            state_q <= ST_IDLE;
            fpend_q <= flush;
          end else begin
            fptr_q <= fptr_q + LN_W'(1);
          end
        end
        ST_FWB: if (mem_hs && last_word) begin
          if (fdone) begin
            state_q <= ST_IDLE;
            fpend_q <= flush;
          end else begin
            state_q <= ST_FSCAN;
            fptr_q  <= fptr_q + LN_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= accept && !req_we;
      if (accept && !req_we) rsp_rdata <= pass_q ? hold_q : ram_rdata;
    end
  end

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_we)
                                   && $stable(req_be) && $stable(req_wdata)));
  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));
  assert_rsp_follows_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready && !req_we));
  assert_write_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_we && !pass_q) |=> !(req_ready && req_we && !pass_q));
  assert_flush_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flushing |-> !req_ready);
endmodule

// File: tb/seg_dcache_bench.sv
module seg_dcache_bench;
  localparam int LINES = 4;
  localparam int LOCK_W = $clog2(LINES + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wb_mode = 1'b1;
  logic [LOCK_W-1:0] lock_lines = '0;
  logic flush = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic req_ready;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [3:0] req_be = '0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic mem_valid, mem_we;
  logic mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic [3:0] mem_be;

  always #5 clk = ~clk;

  seg_dcache #(.LINES(LINES)) u_seg_dcache (
    .clk(clk), .rst_n(rst_n), .wb_mode(wb_mode), .lock_lines(lock_lines), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [31:0] model [1024];
  int rd_n = 0, wr_n = 0;
  logic [7:0] lw = '0;
  int checks = 0, errors = 0;
  bit finished = 0;

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                        input logic [3:0] be);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
    return r;
  endfunction

  function automatic logic [31:0] adr(input int seg, input int tag, input int w);
    return 32'((tag << 6) | (seg << 4) | (w << 2));
  endfunction

  // Backing memory: acknowledges each word after one idle cycle.
  initial begin
    for (int i = 0; i < 1024; i++) model[i] = 32'(i) * 32'h9E3779B1 ^ 32'h5A5A0000;
    forever begin
      @(negedge clk);
      if (mem_ready) mem_ready = 1'b0;
      else if (mem_valid) begin
        if (mem_we) begin
          model[mem_addr[11:2]] = merge(model[mem_addr[11:2]], mem_wdata, mem_be);
          wr_n++;
        end else begin
          mem_rdata = model[mem_addr[11:2]];
          lw = {lw[5:0], mem_addr[3:2]};
          rd_n++;
        end
        mem_ready = 1'b1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [31:0] a, input logic [3:0] be,
                        input logic [31:0] wd, output logic [31:0] rd, output int stalls);
    req_valid = 1'b1; req_we = we; req_addr = a; req_be = be; req_wdata = wd;
    stalls = 0;
    #1;
    while (!req_ready) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_rdata;
    if (!we) chk("R2 rsp_valid after read", 32'(rsp_valid), 32'd1);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
    end
  end

  initial begin
    logic [31:0] rd, exp;
    int st, r0, w0, cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R11 req_ready after reset", 32'(req_ready), 0);
    chk("R11 mem_valid after reset", 32'(mem_valid), 0);
    chk("R11 rsp_valid after reset", 32'(rsp_valid), 0);

    // R1/R3: cold sweep, every segment, four tags
    for (int s = 0; s < 4; s++)
      for (int t = 1; t <= 4; t++) begin
        r0 = rd_n;
        access(0, adr(s, t, t % 4), 0, 0, rd, st);
        chk("R3 fill word count", 32'(rd_n - r0), 4);
        chk("R3 fill order", 32'(lw), 32'h1B);
        chk("R1 miss data", rd, model[adr(s, t, t % 4) >> 2]);
      end
    // R1/R2: warm sweep over all lines and words
    for (int s = 0; s < 4; s++)
      for (int t = 1; t <= 4; t++)
        for (int w = 0; w < 4; w++) begin
          r0 = rd_n;
          access(0, adr(s, t, w), 0, 0, rd, st);
          chk("R2 hit no traffic", 32'(rd_n - r0), 0);
          chk("R2 hit no stall", 32'(st), 0);
          chk("R1 hit data", rd, model[adr(s, t, w) >> 2]);
        end

    // R6: write-back write hit, byte merge
    exp = merge(model[adr(0, 1, 1) >> 2], 32'hC1C2C3C4, 4'b0101);
    w0 = wr_n;
    access(1, adr(0, 1, 1), 4'b0101, 32'hC1C2C3C4, rd, st);
    access(0, adr(0, 1, 1), 0, 0, rd, st);
    chk("R6 merged read back", rd, exp);
    chk("R6 no memory write", 32'(wr_n - w0), 0);
    chk("R6 memory unchanged", model[adr(0, 1, 1) >> 2] == exp ? 1 : 0, 0);

    // R8: back-to-back write hits
    access(1, adr(1, 1, 0), 4'hF, 32'h11110000, rd, st);
    chk("R8 first write no stall", 32'(st), 0);
    access(1, adr(1, 2, 0), 4'hF, 32'h22220000, rd, st);
    chk("R8 second write one stall", 32'(st), 1);
    access(0, adr(1, 2, 0), 0, 0, rd, st);
    access(1, adr(1, 3, 0), 4'hF, 32'h33330000, rd, st);
    chk("R8 write after read no stall", 32'(st), 0);

    // R5/R6: all four seg0 lines dirty, one miss evicts one of them
    for (int t = 1; t <= 4; t++) access(1, adr(0, t, 0), 4'hF, 32'hD0000000 + t, rd, st);
    r0 = rd_n; w0 = wr_n;
    access(0, adr(0, 5, 0), 0, 0, rd, st);
    chk("R6 dirty victim written back", 32'(wr_n - w0), 4);
    chk("R6 refill after writeback", 32'(rd_n - r0), 4);
    cnt = 0;
    for (int t = 1; t <= 4; t++) if (model[adr(0, t, 0) >> 2] == 32'hD0000000 + t) cnt++;
    chk("R6 exactly one line cleaned", 32'(cnt), 1);

    // R9: flush cleans 6 dirty lines then invalidates
    w0 = wr_n;
    @(negedge clk); flush = 1'b1; @(negedge clk); flush = 1'b0;
    r0 = rd_n;
    access(0, adr(1, 1, 0), 0, 0, rd, st);
    chk("R9 flush writebacks", 32'(wr_n - w0), 24);
    chk("R9 read misses after flush", 32'(rd_n - r0), 4);
    chk("R9 flushed data", rd, 32'h11110000);
    cnt = 0;
    for (int t = 1; t <= 4; t++) if (model[adr(0, t, 0) >> 2] == 32'hD0000000 + t) cnt++;
    chk("R9 all seg0 lines cleaned", 32'(cnt), 4);

    // R5: lock lines 0,1 of seg2
    access(0, adr(2, 1, 0), 0, 0, rd, st);
    access(0, adr(2, 2, 0), 0, 0, rd, st);
    lock_lines = 3'd2;
    for (int t = 3; t <= 10; t++) begin
      r0 = rd_n;
      access(0, adr(2, t, 2), 0, 0, rd, st);
      chk("R5 unlocked miss fills", 32'(rd_n - r0), 4);
    end
    r0 = rd_n;
    access(0, adr(2, 1, 3), 0, 0, rd, st);
    access(0, adr(2, 2, 1), 0, 0, rd, st);
    chk("R5 locked lines kept", 32'(rd_n - r0), 0);

    // R7: write-through
    wb_mode = 1'b0;
    w0 = wr_n; r0 = rd_n;
    access(1, adr(2, 1, 3), 4'hF, 32'hABCD0123, rd, st);
    chk("R7 write-through one write", 32'(wr_n - w0), 1);
    chk("R7 memory updated", model[adr(2, 1, 3) >> 2], 32'hABCD0123);
    access(0, adr(2, 1, 3), 0, 0, rd, st);
    chk("R7 line updated", rd, 32'hABCD0123);
    chk("R7 hit after write", 32'(rd_n - r0), 0);
    lock_lines = 3'd0;
    w0 = wr_n;
    for (int t = 11; t <= 18; t++) access(0, adr(2, t, 0), 0, 0, rd, st);
    chk("R7 no dirty evictions", 32'(wr_n - w0), 0);

    // R4: write miss, no allocate
    wb_mode = 1'b1;
    exp = merge(model[adr(3, 20, 2) >> 2], 32'h99887766, 4'b0011);
    w0 = wr_n; r0 = rd_n;
    access(1, adr(3, 20, 2), 4'b0011, 32'h99887766, rd, st);
    chk("R4 one memory write", 32'(wr_n - w0), 1);
    chk("R4 no fill", 32'(rd_n - r0), 0);
    chk("R4 byte enables", model[adr(3, 20, 2) >> 2], exp);
    access(0, adr(3, 20, 2), 0, 0, rd, st);
    chk("R4 later read misses", 32'(rd_n - r0), 4);
    chk("R4 read data", rd, exp);

    // R3: all lines locked -> uncached single-word reads
    lock_lines = 3'd4;
    for (int k = 0; k < 2; k++) begin
      r0 = rd_n;
      access(0, adr(3, 21, 1), 0, 0, rd, st);
      chk("R3 uncached single read", 32'(rd_n - r0), 1);
      chk("R3 uncached word offset", 32'(lw[1:0]), 1);
      chk("R3 uncached data", rd, model[adr(3, 21, 1) >> 2]);
    end

    finished = 1;
    summary();
  end
endmodule